// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns one raw, active-low external interrupt pin into a clean request flag for an interrupt controller. The pin first crosses a two-flop synchronizer. It is then sampled only on the clocks where a machine-cycle strobe is high. A mode register selects one of two behaviours. In level mode the request follows the low sample directly and nothing is latched. In falling-edge mode a high sample followed by a low sample sets a latched flag. That flag also marks the handler as busy: further pin edges are ignored until the controller signals that service is complete.

The controller drives `svc_done` when its return-from-interrupt completes. Software may set or clear the latched flag through a one-cycle write port. A control state machine has three named states. `ST_LEVEL` is the non-latched level mode. `ST_ARMED` is edge mode with the flag clear, waiting for a falling edge. `ST_HELD` is edge mode with the flag set, in service. The transitions are named as follows:
- `go_edge` (ST_LEVEL to ST_ARMED) fires when the mode register reads 1.
- `go_level` (any state to ST_LEVEL) fires when the mode register reads 0.
- `catch` (ST_ARMED to ST_HELD) fires on a detected falling edge.
- `sw_set` and `sw_clr` (ST_ARMED and ST_HELD) follow a software write.
- `release` (ST_HELD to ST_ARMED) fires on `svc_done`.

Top module: `ext_irq_sampler`

## Requirements
- R1: After reset the mode register is 0 (level mode) and `irq_req` is 0 while the pin is high.
- R2: The pin reaches the sampler through a two-flop synchronizer. The sample register loads only on clocks where `mc_stb` is 1. A low pulse on the pin that never coincides with a sampling clock has no effect on `irq_req`.
- R3: In level mode (`mode` = 0), `irq_req` is 1 exactly while the last sample is low. It returns to 0 at the first sample that reads high, with no latching.
- R4: In level mode, `svc_done` has no effect. If the sample is still low after `svc_done`, `irq_req` stays 1.
- R5: In edge mode (`mode` = 1), a sample of 1 followed on the next strobe by a sample of 0 sets the latched flag. `irq_req` becomes 1 at that strobe clock.
- R6: While the flag is set in edge mode, further high-to-low transitions on the pin and the pin's level do not change `irq_req`.
- R7: A one-clock `svc_done` pulse clears the flag in edge mode. A later high-then-low sample pair sets it again.
- R8: A software write (`sw_we` = 1) loads `sw_wdata` into the flag in edge mode. It takes priority over a falling edge and over `svc_done` in the same clock.
- R9: If the pin is already low when edge mode is selected, no request is raised until a high sample has been followed by a low sample.
- R10: Writing `mode_wdata` with `mode_we` = 1 updates the mode register on that clock. Returning to level mode drops any latched flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 1 | Raw active-low external interrupt pin |
| mc_stb | input | 1 | Machine-cycle strobe; the pin sample updates when 1 |
| mode_we | input | 1 | Write enable for the mode register |
| mode_wdata | input | 1 | New mode: 0 level, 1 falling edge |
| svc_done | input | 1 | Return-from-interrupt strobe, one clock |
| sw_we | input | 1 | Software write enable for the latched flag |
| sw_wdata | input | 1 | Value written into the latched flag |
| irq_req | output | 1 | Request to the controller; in edge mode also the in-service flag |

## Verification
The bench aims at short low glitches that fall between two machine-cycle strobes. A design that sampled on every clock would raise a spurious level request for them. It also turns on edge mode while the pin is already low; a design that treated the reset state of the sample as a real high would latch a phantom edge there. Bursts of pin edges during service check that the flag is not re-armed early. A software clear is written in the same strobe as a real edge; a design with the wrong priority would leave the flag set. Finally, `svc_done` is sent in level mode with the pin still low; a design that latched in level mode would drop the request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        ST_LEVEL = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } req_state_t;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RESET_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pin_s,
    output logic samp_q,
    output logic fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   samp_q <= 1'b1;
        else if (stb) samp_q <= pin_s;
    end

    // high sample held from the previous machine cycle, low one arriving now
    assign fall = stb & samp_q & ~pin_s;

    // R2: the sample only moves on strobe clocks
    a_r2_sample_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(samp_q));
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_q,
    input  logic fall,
    input  logic samp_q,
    input  logic svc_done,
    input  logic sw_we,
    input  logic sw_wdata,
    output logic irq_req
);
    req_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEVEL: if (mode_q) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!mode_q)    state_d = ST_LEVEL;
                else if (sw_we) state_d = sw_wdata ? ST_HELD : ST_ARMED;
                else if (fall)  state_d = ST_HELD;
            end
            ST_HELD: begin
                if (!mode_q)       state_d = ST_LEVEL;
                else if (sw_we)    state_d = sw_wdata ? ST_HELD : ST_ARMED;
                else if (svc_done) state_d = ST_ARMED;
            end
            default: state_d = ST_LEVEL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEVEL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_LEVEL: irq_req = ~samp_q;
            ST_ARMED: irq_req = 1'b0;
            ST_HELD:  irq_req = 1'b1;
            default:  irq_req = 1'b0;
        endcase
    end

    // R5: a detected edge while armed latches the flag
    a_r5_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && mode_q && !sw_we && fall) |=> irq_req);

    // R6: in service, pin activity leaves the flag alone
    a_r6_held_ignores_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && mode_q && !sw_we && !svc_done) |=> irq_req);

    // R7: service completion re-arms
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && mode_q && !sw_we && svc_done) |=> !irq_req);

    // R8: a software clear wins over a same-cycle edge
    a_r8_sw_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && mode_q && sw_we && !sw_wdata && fall) |=> !irq_req);
endmodule

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic mc_stb,
    input  logic mode_we,
    input  logic mode_wdata,
    input  logic svc_done,
    input  logic sw_we,
    input  logic sw_wdata,
    output logic irq_req
);
    logic mode_q;
    logic pin_s;
    logic samp_q;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (pin_s)
    );

    irq_pin_sampler u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (mc_stb),
        .pin_s  (pin_s),
        .samp_q (samp_q),
        .fall   (fall)
    );

    irq_req_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .fall     (fall),
        .samp_q   (samp_q),
        .svc_done (svc_done),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .irq_req  (irq_req)
    );

    // R10: the mode register takes a write on the same clock
    a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q == $past(mode_wdata)));
endmodule

// File: tb/test_ext_irq_sampler.sv
module test_ext_irq_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int STB_DIV    = 4;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic mc_stb = 1'b0;
    logic mode_we = 1'b0, mode_wdata = 1'b0;
    logic svc_done = 1'b0;
    logic sw_we = 1'b0, sw_wdata = 1'b0;
    logic irq_req;

    int vectors = 0;
    int errors  = 0;
    int stb_cnt = 0;
    string tag = "R1";

    // reference state, written from the requirements
    logic m1, m2, ms, mmode, mlevel, mheld;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_sampler i_ext_irq_sampler (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mc_stb(mc_stb),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .svc_done(svc_done),
        .sw_we(sw_we), .sw_wdata(sw_wdata), .irq_req(irq_req)
    );

    function automatic logic expected_req(logic lvl, logic held, logic samp);
        return lvl ? ~samp : held;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 = 1'b1; m2 = 1'b1; ms = 1'b1;
            mmode = 1'b0; mlevel = 1'b1; mheld = 1'b0;
        end else begin
            logic edge_seen;
            edge_seen = mc_stb && ms && !m2;
            if (!mmode) begin
                mlevel = 1'b1; mheld = 1'b0;
            end else if (mlevel) begin
                mlevel = 1'b0;
            end else if (sw_we) begin
                mheld = sw_wdata;
            end else if (!mheld && edge_seen) begin
                mheld = 1'b1;
            end else if (mheld && svc_done) begin
                mheld = 1'b0;
            end
            if (mc_stb) ms = m2;
            m2 = m1;
            m1 = pin_n;
            if (mode_we) mmode = mode_wdata;
        end
    end

    task automatic check(string t, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_req actual %0b expected %0b at %0t", t, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) check(tag, irq_req, expected_req(mlevel, mheld, ms));
    end

    // strobe generator
    always @(negedge clk) begin
        stb_cnt <= (stb_cnt == STB_DIV - 1) ? 0 : stb_cnt + 1;
        mc_stb  <= (stb_cnt == STB_DIV - 1);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_stb();
        @(negedge clk);
        while (!mc_stb) @(negedge clk);
    endtask

    task automatic set_mode(logic m);
        mode_we = 1'b1; mode_wdata = m;
        step(1);
        mode_we = 1'b0;
        step(2);
    endtask

    task automatic pulse_svc();
        svc_done = 1'b1; step(1); svc_done = 1'b0;
    endtask

    task automatic sw_write(logic v);
        sw_we = 1'b1; sw_wdata = v; step(1); sw_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(3);
        check("R1", irq_req, 1'b0);
        rst_n = 1'b1;
        step(6);
        check("R1", irq_req, 1'b0);

        // R2: glitch between strobes
        tag = "R2";
        wait_stb();
        pin_n = 1'b0; step(1); pin_n = 1'b1;
        step(10);
        check("R2", irq_req, 1'b0);

        // R3: level follows sample, no latch
        tag = "R3";
        pin_n = 1'b0; step(12);
        check("R3", irq_req, 1'b1);
        pin_n = 1'b1; step(12);
        check("R3", irq_req, 1'b0);

        // R4: svc_done in level mode with pin still low
        tag = "R4";
        pin_n = 1'b0; step(12);
        pulse_svc(); step(6);
        check("R4", irq_req, 1'b1);

        // R9: entering edge mode with the pin low
        tag = "R9";
        set_mode(1'b1); step(12);
        check("R9", irq_req, 1'b0);

        // R5: high then low
        tag = "R5";
        pin_n = 1'b1; step(12);
        pin_n = 1'b0; step(12);
        check("R5", irq_req, 1'b1);

        // R6: burst of edges in service
        tag = "R6";
        for (int i = 0; i < 6; i++) begin
            pin_n = 1'b1; step(8); pin_n = 1'b0; step(8);
        end
        pin_n = 1'b1; step(10);
        check("R6", irq_req, 1'b1);

        // R7: release and re-arm
        tag = "R7";
        pulse_svc(); step(2);
        check("R7", irq_req, 1'b0);
        pin_n = 1'b0; step(12);
        check("R7", irq_req, 1'b1);

        // R8: software writes and priority over an edge
        tag = "R8";
        sw_write(1'b0); step(1);
        check("R8", irq_req, 1'b0);
        sw_write(1'b1); step(1);
        check("R8", irq_req, 1'b1);
        sw_write(1'b0);
        pin_n = 1'b1; step(12);
        pin_n = 1'b0; sw_we = 1'b1; sw_wdata = 1'b0;
        step(10);
        sw_we = 1'b0; step(4);
        check("R8", irq_req, 1'b0);

        // R10: back to level mode drops the flag
        tag = "R10";
        pin_n = 1'b1; step(12);
        sw_write(1'b1); step(1);
        check("R10", irq_req, 1'b1);
        set_mode(1'b0); step(2);
        check("R10", irq_req, 1'b0);

        // random mix
        tag = "random R3 R5 R6 R7 R8";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 12) pin_n = ~pin_n;
            svc_done = ($urandom_range(0, 99) < 6);
            sw_we    = ($urandom_range(0, 99) < 3);
            sw_wdata = $urandom_range(0, 1);
            mode_we  = ($urandom_range(0, 999) < 4);
            mode_wdata = $urandom_range(0, 3) != 0;
            step(1);
        end
        svc_done = 1'b0; sw_we = 1'b0; mode_we = 1'b0;
        step(4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule